// File: doc/BRIEF.md
# Serial Transmit Engine with Break and Synchronous Mode

This block is the transmit half of a serial port. Software (or an upstream block) offers a byte plus an optional ninth bit on a valid/ready stream. The engine buffers one entry in a holding stage and moves it into a shift register, which drives the serial line. Asynchronous mode frames each character with a low start bit and a high stop bit. The length of each bit is a count of pulses from an external baud-tick source: 16 ticks at normal speed and 4 at fast speed.

Synchronous mode sends the bare data bits, LSB first, with no framing. The bits are aligned to a shift clock. As master, the engine toggles `sclk_out` on every baud tick. As slave, it follows an external clock on `sclk_in`. In both cases the data changes after a falling edge and is stable around the rising edge.

A one-shot break request, valid only in asynchronous mode, sends a character made of thirteen low bit times followed by a stop bit. A status output reports whether the shift register is empty.

The stream follows these rules. `in_ready` is high only while the engine is enabled and the holding stage is empty. A beat transfers on a cycle where `in_valid` and `in_ready` are both high. While a frame is in flight and the holding stage is full, `in_ready` stays low, and the upstream side must hold its beat until `in_ready` goes high again.

Top module: `sertx_engine`

## Requirements
- R1: After reset, `txd` = 1, `tsr_empty` = 1, `sclk_out` = 0, `brk_pending` = 0. `in_ready` = 0 while `cfg_enable` = 0.
- R2: While `cfg_enable` = 0, the engine is idle and `in_ready` = 0. Clearing `cfg_enable` during a frame aborts it, and the next cycle shows `txd` = 1 and `tsr_empty` = 1.
- R3: In asynchronous mode (`cfg_sync` = 0), a frame is bit 0 (start, 0), then `in_data[0]` to `in_data[7]`, then the stop bit (1). At `cfg_fast` = 0, each bit lasts 16 baud ticks.
- R4: In asynchronous mode with `cfg_fast` = 1, each bit lasts 4 baud ticks.
- R5: With `cfg_nine` = 1, `in_bit9` is sent right after `in_data[7]`. With `cfg_nine` = 0, `in_bit9` is not sent.
- R6: `in_ready` = `cfg_enable` and holding stage empty. A beat accepted during a frame drops `in_ready` for the next cycle. That beat's frame starts right after the current frame ends.
- R7: `tsr_empty` is 0 while a frame is being shifted and 1 when the engine is idle. The line is high whenever `tsr_empty` = 1.
- R8: A `brk_set` pulse in asynchronous mode sets `brk_pending`. The next frame is thirteen 0 bit times followed by a 1 stop bit. `brk_pending` clears when that stop bit completes.
- R9: When a break request and a held data beat are both waiting while the shift register is empty, the break goes first and the data frame follows.
- R10: `brk_set` has no effect when `cfg_sync` = 1: `brk_pending` stays 0.
- R11: In synchronous master mode (`cfg_sync` = 1, `cfg_master` = 1), `sclk_out` toggles on each baud tick. Data bits go out LSB first with no start or stop bits, one per rising edge, 8 bits (9 with `cfg_nine`). `txd` changes only after a falling edge.
- R12: In synchronous slave mode (`cfg_master` = 0), `sclk_out` stays 0. Each falling edge of `sclk_in` advances to the next data bit.
- R13: `cfg_master` has no effect in asynchronous mode: `sclk_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Transmitter enable |
| cfg_sync | input | 1 | 1 = synchronous mode, 0 = asynchronous |
| cfg_master | input | 1 | Synchronous clock source: 1 = master, 0 = slave |
| cfg_nine | input | 1 | 1 = send ninth data bit |
| cfg_fast | input | 1 | Asynchronous speed: 1 = 4 ticks per bit, 0 = 16 |
| brk_set | input | 1 | Pulse to request a break character |
| baud_tick | input | 1 | One-cycle pulse from the baud generator |
| in_valid | input | 1 | Data beat valid |
| in_ready | output | 1 | Holding stage can accept a beat |
| in_data | input | 8 | Data byte |
| in_bit9 | input | 1 | Ninth data bit |
| sclk_in | input | 1 | External shift clock (slave) |
| txd | output | 1 | Serial data line |
| sclk_out | output | 1 | Shift clock driven in master mode |
| tsr_empty | output | 1 | Shift register empty |
| brk_pending | output | 1 | Break requested and not yet completed |

## Verification
A break request and a data beat can be waiting in the same cycle when the shift register goes empty. The engine has to pick one to launch first. The bench provokes this by pulsing `brk_set` and offering a data beat in the same cycle while the line is idle. It then decodes the line and expects, in order: a break frame of thirteen zeros and a stop bit, followed directly by the data frame. It also expects `brk_pending` to be high before the break and low after it.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int FRAME_W   = 14;
  localparam int LEN_W     = $clog2(FRAME_W + 1);
  localparam int DATA_W    = 8;
  localparam int HOLD_W    = DATA_W + 1;

  typedef enum logic [1:0] {
    MODE_ASYNC   = 2'd0,
    MODE_SMASTER = 2'd1,
    MODE_SSLAVE  = 2'd2
  } txmode_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;
    logic               brk;
  } frame_t;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] q
);
  assign in_ready = !flush && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else if (flush) begin
      full <= 1'b0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
      q    <= in_word;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_timing.sv
module sertx_timing
  import sertx_pkg::*;
#(
  parameter int SLOW_TPB    = 16,
  parameter int FAST_TPB    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  txmode_e mode,
  input  logic    fast,
  input  logic    baud_tick,
  input  logic    sclk_in,
  output logic    step,
  output logic    sclk_q
);
  localparam int MAX_TPB = (SLOW_TPB > FAST_TPB) ? SLOW_TPB : FAST_TPB;
  localparam int TW      = (MAX_TPB > 1) ? $clog2(MAX_TPB) : 1;

  logic [TW-1:0] tcnt;
  logic [TW-1:0] tlast;
  logic          fall;

  assign tlast = fast ? TW'(FAST_TPB - 1) : TW'(SLOW_TPB - 1);

  // external clock resynchronisation, depth chosen by parameter
  logic [SYNC_STAGES:0] chain;
  logic                 sl_prev;
  assign chain[0] = sclk_in;
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic stage_q;
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q <= 1'b0;
      else        stage_q <= chain[g];
    end
    assign chain[g+1] = stage_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sl_prev <= 1'b0;
    else        sl_prev <= chain[SYNC_STAGES];
  end
  assign fall = sl_prev && !chain[SYNC_STAGES];

  always_comb begin
    unique case (mode)
      MODE_ASYNC:   step = run && baud_tick && (tcnt == tlast);
      MODE_SMASTER: step = run && baud_tick && sclk_q;
      MODE_SSLAVE:  step = run && fall;
      default:      step = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (!run || mode != MODE_ASYNC) begin
      tcnt <= '0;
    end else if (baud_tick) begin
      tcnt <= (tcnt == tlast) ? '0 : tcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
    end else if (!run || mode != MODE_SMASTER) begin
      sclk_q <= 1'b0;
    end else if (baud_tick) begin
      sclk_q <= !sclk_q;
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  txmode_e           mode,
  input  logic              nine,
  input  logic              hold_full,
  input  logic [HOLD_W-1:0] hold_q,
  input  logic              brk_pend,
  input  logic              step,
  output logic              take,
  output logic              brk_done,
  output logic              active,
  output logic              txd
);
  localparam int ZERO_RUN = FRAME_W - 1;

  frame_t             nxt;
  logic               start_brk;
  logic [FRAME_W-1:0] sh;
  logic [LEN_W-1:0]   left;
  logic               in_brk;
  logic [DATA_W-1:0]  d;
  logic               b9;

  assign d  = hold_q[DATA_W-1:0];
  assign b9 = hold_q[DATA_W];

  assign start_brk = enable && !active && brk_pend && (mode == MODE_ASYNC);
  assign take      = enable && !active && hold_full && !start_brk;

  always_comb begin
    nxt = '0;
    if (start_brk) begin
      nxt.bits = {1'b1, {ZERO_RUN{1'b0}}};
      nxt.len  = LEN_W'(FRAME_W);
      nxt.brk  = 1'b1;
    end else if (mode == MODE_ASYNC) begin
      if (nine) begin
        nxt.bits = {{(FRAME_W-DATA_W-3){1'b1}}, 1'b1, b9, d, 1'b0};
        nxt.len  = LEN_W'(DATA_W + 3);
      end else begin
        nxt.bits = {{(FRAME_W-DATA_W-2){1'b1}}, 1'b1, d, 1'b0};
        nxt.len  = LEN_W'(DATA_W + 2);
      end
    end else begin
      if (nine) begin
        nxt.bits = {{(FRAME_W-DATA_W-1){1'b1}}, b9, d};
        nxt.len  = LEN_W'(DATA_W + 1);
      end else begin
        nxt.bits = {{(FRAME_W-DATA_W){1'b1}}, d};
        nxt.len  = LEN_W'(DATA_W);
      end
    end
  end

  assign brk_done = active && in_brk && step && (left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sh     <= '1;
      left   <= '0;
      in_brk <= 1'b0;
    end else if (!enable) begin
      active <= 1'b0;
      sh     <= '1;
      left   <= '0;
      in_brk <= 1'b0;
    end else if (!active) begin
      if (start_brk || take) begin
        active <= 1'b1;
        sh     <= nxt.bits;
        left   <= nxt.len;
        in_brk <= nxt.brk;
      end
    end else if (step) begin
      sh   <= {1'b1, sh[FRAME_W-1:1]};
      left <= left - 1'b1;
      if (left == LEN_W'(1)) begin
        active <= 1'b0;
        in_brk <= 1'b0;
      end
    end
  end

  assign txd = active ? sh[0] : 1'b1;
endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
  import sertx_pkg::*;
#(
  parameter int SLOW_TPB    = 16,
  parameter int FAST_TPB    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_sync,
  input  logic              cfg_master,
  input  logic              cfg_nine,
  input  logic              cfg_fast,
  input  logic              brk_set,
  input  logic              baud_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_bit9,
  input  logic              sclk_in,
  output logic              txd,
  output logic              sclk_out,
  output logic              tsr_empty,
  output logic              brk_pending
);
  txmode_e           mode;
  logic              hold_full;
  logic [HOLD_W-1:0] hold_q;
  logic              take;
  logic              brk_done;
  logic              active;
  logic              step;

  always_comb begin
    if (!cfg_sync)       mode = MODE_ASYNC;
    else if (cfg_master) mode = MODE_SMASTER;
    else                 mode = MODE_SSLAVE;
  end

  sertx_hold #(.W(HOLD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (!cfg_enable),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_word  ({in_bit9, in_data}),
    .take     (take),
    .full     (hold_full),
    .q        (hold_q)
  );

  sertx_timing #(
    .SLOW_TPB    (SLOW_TPB),
    .FAST_TPB    (FAST_TPB),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (active),
    .mode      (mode),
    .fast      (cfg_fast),
    .baud_tick (baud_tick),
    .sclk_in   (sclk_in),
    .step      (step),
    .sclk_q    (sclk_out)
  );

  sertx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_enable),
    .mode      (mode),
    .nine      (cfg_nine),
    .hold_full (hold_full),
    .hold_q    (hold_q),
    .brk_pend  (brk_pending),
    .step      (step),
    .take      (take),
    .brk_done  (brk_done),
    .active    (active),
    .txd       (txd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                   brk_pending <= 1'b0;
    else if (brk_done)            brk_pending <= 1'b0;
    else if (brk_set && !cfg_sync) brk_pending <= 1'b1;
  end

  assign tsr_empty = !active;
endmodule

// File: rtl/sertx_engine_chk.sv
module sertx_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_enable,
  input logic       cfg_sync,
  input logic       cfg_master,
  input logic       in_valid,
  input logic       in_ready,
  input logic       txd,
  input logic       sclk_out,
  input logic       tsr_empty,
  input logic       brk_pending
);
  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (tsr_empty && txd));

  a_r6_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r7_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tsr_empty |-> txd);

  a_r8_break_ends_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_pending) |-> tsr_empty);

  a_r10_break_ignored_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync && !brk_pending) |=> !brk_pending);

  a_r11_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_out && $past(sclk_out)) |-> $stable(txd));

  a_r13_no_clock_unless_master: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_sync && cfg_master) |=> !sclk_out);
endmodule

bind sertx_engine sertx_engine_chk chk_i (.*);

// File: tb/sertx_engine_tb.sv
`timescale 1ns/1ps
module sertx_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0, cfg_sync = 1'b0, cfg_master = 1'b0;
  logic       cfg_nine = 1'b0, cfg_fast = 1'b0, brk_set = 1'b0;
  logic       baud_tick = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_bit9 = 1'b0;
  logic       sclk_in = 1'b0;
  logic       in_ready, txd, sclk_out, tsr_empty, brk_pending;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sertx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_sync(cfg_sync),
    .cfg_master(cfg_master), .cfg_nine(cfg_nine), .cfg_fast(cfg_fast),
    .brk_set(brk_set), .baud_tick(baud_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_bit9(in_bit9),
    .sclk_in(sclk_in), .txd(txd), .sclk_out(sclk_out),
    .tsr_empty(tsr_empty), .brk_pending(brk_pending)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] d, logic b9);
    int w = 0;
    @(negedge clk);
    while (!in_ready && w < 2000) begin @(negedge clk); w++; end
    in_valid = 1'b1; in_data = d; in_bit9 = b9;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic grab_async(int n, int tpb, output logic [15:0] v);
    int w = 0;
    v = '0;
    while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    repeat (tpb/2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      v[i] = txd;
      if (i != n-1) repeat (tpb) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 txd", 32'(txd), 1);
    check("R1 tsr_empty", 32'(tsr_empty), 1);
    check("R1 sclk_out", 32'(sclk_out), 0);
    check("R1 brk_pending", 32'(brk_pending), 0);
    check("R1 in_ready", 32'(in_ready), 0);
  endtask

  task automatic t_async8();
    logic [15:0] v;
    int clk_seen = 0;
    cfg_enable = 1; cfg_sync = 0; cfg_master = 1; cfg_nine = 0; cfg_fast = 0;
    send(8'hA5, 1'b0);
    fork
      grab_async(10, 16, v);
      repeat (170) begin @(negedge clk); if (sclk_out) clk_seen++; end
    join
    check("R3 R5 async 8-bit frame", 32'(v[9:0]), 32'({1'b1, 8'hA5, 1'b0}));
    check("R13 no clock in async", 32'(clk_seen), 0);
    repeat (20) @(negedge clk);
    check("R7 idle after frame", 32'(tsr_empty), 1);
  endtask

  task automatic t_async_fast9();
    logic [15:0] v;
    cfg_fast = 1; cfg_nine = 1; cfg_master = 0;
    send(8'h3C, 1'b1);
    grab_async(11, 4, v);
    check("R4 R5 fast nine-bit frame", 32'(v[10:0]), 32'({1'b1, 1'b1, 8'h3C, 1'b0}));
    repeat (8) @(negedge clk);
    check("R7 idle after fast frame", 32'(tsr_empty), 1);
    cfg_fast = 0; cfg_nine = 0;
  endtask

  task automatic t_backtoback();
    logic [15:0] v1, v2;
    send(8'h81, 1'b0);
    send(8'h1E, 1'b0);
    check("R6 ready low while held", 32'(in_ready), 0);
    check("R7 busy during frame", 32'(tsr_empty), 0);
    grab_async(10, 16, v1);
    grab_async(10, 16, v2);
    check("R6 first frame", 32'(v1[9:0]), 32'({1'b1, 8'h81, 1'b0}));
    check("R6 second frame", 32'(v2[9:0]), 32'({1'b1, 8'h1E, 1'b0}));
    repeat (20) @(negedge clk);
  endtask

  task automatic t_break();
    logic [15:0] v;
    @(negedge clk); brk_set = 1; @(negedge clk); brk_set = 0;
    check("R8 break pending set", 32'(brk_pending), 1);
    grab_async(14, 16, v);
    check("R8 break frame", 32'(v[13:0]), 32'({1'b1, 13'b0}));
    repeat (16) @(negedge clk);
    check("R8 break pending cleared", 32'(brk_pending), 0);
    check("R8 idle after break", 32'(tsr_empty), 1);
  endtask

  task automatic t_break_prio();
    logic [15:0] vb, vd;
    @(negedge clk);
    check("R9 ready before collision", 32'(in_ready), 1);
    brk_set = 1; in_valid = 1; in_data = 8'h5A; in_bit9 = 0;
    @(negedge clk);
    brk_set = 0; in_valid = 0;
    check("R9 break pending", 32'(brk_pending), 1);
    grab_async(14, 16, vb);
    grab_async(10, 16, vd);
    check("R9 break first", 32'(vb[13:0]), 32'({1'b1, 13'b0}));
    check("R9 data after break", 32'(vd[9:0]), 32'({1'b1, 8'h5A, 1'b0}));
    check("R9 break cleared", 32'(brk_pending), 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_sync_master();
    logic [8:0] got = '0;
    int k = 0, w = 0, extra = 0;
    logic prev;
    cfg_sync = 1; cfg_master = 1; cfg_nine = 1;
    @(negedge clk); brk_set = 1; @(negedge clk); brk_set = 0;
    check("R10 break ignored in sync", 32'(brk_pending), 0);
    prev = sclk_out;
    send(8'h96, 1'b1);
    while (k < 9 && w < 400) begin
      @(negedge clk); w++;
      if (!prev && sclk_out) begin got[k] = txd; k++; end
      prev = sclk_out;
    end
    repeat (10) begin
      @(negedge clk);
      if (!prev && sclk_out) extra++;
      prev = sclk_out;
    end
    check("R11 master bits", 32'(got), 32'({1'b1, 8'h96}));
    check("R11 no extra edges", 32'(extra), 0);
    check("R11 clock parked low", 32'(sclk_out), 0);
    check("R10 still no break", 32'(brk_pending), 0);
    check("R7 idle after sync", 32'(tsr_empty), 1);
  endtask

  task automatic t_sync_slave();
    logic [7:0] got = '0;
    int clk_seen = 0;
    cfg_master = 0; cfg_nine = 0;
    send(8'hC3, 1'b0);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1;
      repeat (3) @(negedge clk);
      got[i] = txd;
      if (sclk_out) clk_seen++;
      repeat (3) @(negedge clk);
      sclk_in = 0;
      repeat (6) @(negedge clk);
      if (sclk_out) clk_seen++;
    end
    check("R12 slave bits", 32'(got), 32'(8'hC3));
    check("R12 no driven clock", 32'(clk_seen), 0);
    check("R12 idle after slave frame", 32'(tsr_empty), 1);
    cfg_sync = 0;
  endtask

  task automatic t_disable();
    int w = 0;
    send(8'h00, 1'b0);
    repeat (40) @(negedge clk);
    check("R2 frame in flight", 32'(tsr_empty), 0);
    cfg_enable = 0;
    @(negedge clk);
    check("R2 abort empties", 32'(tsr_empty), 1);
    check("R2 abort line high", 32'(txd), 1);
    check("R2 not ready", 32'(in_ready), 0);
    in_valid = 1; in_data = 8'h00;
    repeat (50) begin @(negedge clk); if (txd !== 1'b1) w++; end
    in_valid = 0;
    check("R2 no transmission while off", 32'(w), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_async8();
    t_async_fast9();
    t_backtoback();
    t_break();
    t_break_prio();
    t_sync_master();
    t_sync_slave();
    t_disable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule